// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken by running two direction predictors side by side and letting a per-address selector pick between them. The first predictor follows the pattern of the most recent resolved outcomes across all branches. It indexes a table of 2-bit saturating counters with a global outcome history. The second predictor works in two levels. A per-address table keeps each branch's own recent outcomes, and that pattern indexes a table of 3-bit saturating counters.

A fetch stage presents a PC with `fetch_valid`. One cycle later the block returns the final direction and a flag that tells which component supplied it. A resolution stage presents a branch PC with its actual outcome on `upd_valid`. On every resolution both components, the global history and the per-branch history are trained. The selector counter for that address moves toward a component only when that component alone was right.

After reset the block sweeps every table entry to its initial value and holds `ready` low while it does so. Sizes are parameters. The defaults give a 12-bit global history, 1024 local history entries of 10 bits, and a 4096-entry selector.

Top module: `tourney_bp`

## Requirements
- R1: After reset `ready` stays low for 2**IW clock edges, where IW is the widest table index. It then rises and stays high. The first lookup after that predicts not-taken with `pred_global` = 0.
- R2: A lookup presented with `fetch_valid` in cycle t shows its result on `pred_valid`, `pred_taken` and `pred_global` after the clock edge that ends cycle t. `pred_valid` is 0 for any cycle in which `fetch_valid` was low.
- R3: The global history is GHIST_W bits long. Each resolved outcome is shifted into bit 0 (1 = taken). The history indexes 2-bit counters that reset to 1, predict taken at 2 or 3, and saturate at 0 and 3.
- R4: Each branch's local history is LHIST_W bits long and is selected by PC bits [ALIGN +: LADDR_W]. Every resolution of that branch shifts its outcome into bit 0. Local histories reset to 0.
- R5: The local pattern indexes 3-bit counters that reset to 3, predict taken at 4 or more, and saturate at 0 and 7.
- R6: The selector entry is chosen by PC bits [ALIGN +: SEL_W]. A value of 2 or 3 selects the global prediction (`pred_global` = 1) and a value of 0 or 1 selects the local prediction. Selector entries reset to 1.
- R7: On resolution the selector entry steps up by one, saturating at 3, when only the global component was right. It steps down by one, saturating at 0, when only the local component was right. When both were right or both were wrong it is left unchanged.
- R8: Every resolution trains both components and both histories, whichever component the selector currently favours. With `upd_valid` low the global history holds.
- R9: When a lookup and a resolution occur in the same cycle, including for the same PC, the lookup sees the table and history state from before that resolution.
- R10: While `ready` is low, lookups produce `pred_valid` = 0 and resolutions change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Lookup request |
| fetch_pc | input | PC_W | PC to predict |
| upd_valid | input | 1 | Resolution strobe |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |
| ready | output | 1 | Table initialisation finished |
| pred_valid | output | 1 | Registered lookup result valid |
| pred_taken | output | 1 | Final predicted direction |
| pred_global | output | 1 | 1 when the global component was chosen |

## Verification
Lookup and training can fall in the same cycle, and their interaction is where ordering errors hide. If a lookup sees an entry that is being trained in that cycle, the lookup must get the pre-training value. The bench provokes this by driving `fetch_pc` equal to `upd_pc` for long runs of random outcomes, and also by interleaving unrelated PCs whose selector and local entries alias in a small configuration. A bench-side model computes each prediction from its state before applying that cycle's training. Every returned direction and chooser flag is compared with that model one edge later.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

  // 2-bit saturating step toward the observed direction
  function automatic logic [1:0] sat2_step(input logic [1:0] c, input logic up);
    if (up) return (c == 2'b11) ? c : c + 2'd1;
    else    return (c == 2'b00) ? c : c - 2'd1;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/tbp_global.sv
module tbp_global import tbp_pkg::*; #(
  parameter int HW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init_en,
  input  logic [HW-1:0] init_idx,
  input  logic          upd_en,
  input  logic          upd_taken,
  output logic          g_pred,
  output logic [HW-1:0] ghist_o
);
  localparam int DEPTH = 2**HW;

  logic [1:0]    ctr [DEPTH];
  logic [HW-1:0] ghist;

  // History is non-speculative, so lookup and training share one index
  assign g_pred  = ctr[ghist][1];
  assign ghist_o = ghist;

  always_ff @(posedge clk) begin
    if (init_en)
      ctr[init_idx] <= 2'd1;
    else if (upd_en)
      ctr[ghist] <= sat2_step(ctr[ghist], upd_taken);
  end

  always_ff @(posedge clk) begin
    if (rst)
      ghist <= '0;
    else if (upd_en)
      ghist <= {ghist[HW-2:0], upd_taken};
  end
endmodule

// File: rtl/tbp_local.sv
module tbp_local #(
  parameter int AW = 10,
  parameter int HW = 10,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          init_en,
  input  logic [AW-1:0] init_a,
  input  logic [HW-1:0] init_h,
  input  logic [AW-1:0] lk_idx,
  input  logic [AW-1:0] up_idx,
  input  logic          upd_en,
  input  logic          upd_taken,
  output logic          lk_pred,
  output logic          up_pred
);
  localparam int HDEPTH = 2**AW;
  localparam int CDEPTH = 2**HW;
  localparam logic [CW-1:0] CMAX  = {CW{1'b1}};
  localparam logic [CW-1:0] C_RST = {1'b0, {(CW-1){1'b1}}};

  logic [HW-1:0] lht [HDEPTH];
  logic [CW-1:0] lct [CDEPTH];

  logic [HW-1:0] lk_pat, up_pat;
  logic [CW-1:0] up_ctr, up_next;

  assign lk_pat  = lht[lk_idx];
  assign lk_pred = lct[lk_pat][CW-1];
  assign up_pat  = lht[up_idx];
  assign up_ctr  = lct[up_pat];
  assign up_pred = up_ctr[CW-1];

  always_comb begin
    up_next = up_ctr;
    if (upd_taken && up_ctr != CMAX)    up_next = up_ctr + 1'b1;
    else if (!upd_taken && up_ctr != '0) up_next = up_ctr - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (init_en) begin
      lht[init_a] <= '0;
      lct[init_h] <= C_RST;
    end else if (upd_en) begin
      lht[up_idx] <= {up_pat[HW-2:0], upd_taken};
      lct[up_pat] <= up_next;
    end
  end
endmodule

// File: rtl/tbp_chooser.sv
module tbp_chooser import tbp_pkg::*; #(
  parameter int SW = 12
) (
  input  logic          clk,
  input  logic          init_en,
  input  logic [SW-1:0] init_s,
  input  logic [SW-1:0] lk_idx,
  input  logic [SW-1:0] up_idx,
  input  logic          upd_en,
  input  logic          g_ok,
  input  logic          l_ok,
  output logic          lk_global
);
  localparam int DEPTH = 2**SW;

  logic [1:0] sel [DEPTH];

  assign lk_global = sel[lk_idx][1];

  always_ff @(posedge clk) begin
    if (init_en)
      sel[init_s] <= 2'd1;
    else if (upd_en && (g_ok != l_ok))
      sel[up_idx] <= sat2_step(sel[up_idx], g_ok);
  end
endmodule

// File: rtl/tourney_bp.sv
module tourney_bp import tbp_pkg::*; #(
  parameter int PC_W    = 32,
  parameter int ALIGN   = 2,
  parameter int GHIST_W = 12,
  parameter int LADDR_W = 10,
  parameter int LHIST_W = 10,
  parameter int LCTR_W  = 3,
  parameter int SEL_W   = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fetch_valid,
  input  logic [PC_W-1:0] fetch_pc,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  output logic            ready,
  output logic            pred_valid,
  output logic            pred_taken,
  output logic            pred_global
);
  localparam int IW = imax(imax(GHIST_W, SEL_W), imax(LADDR_W, LHIST_W));

  logic [IW-1:0]      init_idx;
  logic               init_en, upd_fire;
  logic               g_pred, l_lk_pred, l_up_pred, lk_global;
  logic [GHIST_W-1:0] ghist;

  logic [LADDR_W-1:0] l_lk_idx, l_up_idx;
  logic [SEL_W-1:0]   s_lk_idx, s_up_idx;

  assign l_lk_idx = fetch_pc[ALIGN +: LADDR_W];
  assign l_up_idx = upd_pc[ALIGN +: LADDR_W];
  assign s_lk_idx = fetch_pc[ALIGN +: SEL_W];
  assign s_up_idx = upd_pc[ALIGN +: SEL_W];

  logic unused_pc_bits;
  assign unused_pc_bits = ^{fetch_pc, upd_pc};

  // Initialisation sweep over the widest table
  always_ff @(posedge clk) begin
    if (rst) begin
      ready    <= 1'b0;
      init_idx <= '0;
    end else if (!ready) begin
      init_idx <= init_idx + 1'b1;
      if (&init_idx) ready <= 1'b1;
    end
  end

  assign init_en  = !ready;
  assign upd_fire = upd_valid && ready;

  tbp_global #(.HW(GHIST_W)) u_glob (
    .clk      (clk),
    .rst      (rst),
    .init_en  (init_en),
    .init_idx (init_idx[GHIST_W-1:0]),
    .upd_en   (upd_fire),
    .upd_taken(upd_taken),
    .g_pred   (g_pred),
    .ghist_o  (ghist)
  );

  tbp_local #(.AW(LADDR_W), .HW(LHIST_W), .CW(LCTR_W)) u_loc (
    .clk      (clk),
    .init_en  (init_en),
    .init_a   (init_idx[LADDR_W-1:0]),
    .init_h   (init_idx[LHIST_W-1:0]),
    .lk_idx   (l_lk_idx),
    .up_idx   (l_up_idx),
    .upd_en   (upd_fire),
    .upd_taken(upd_taken),
    .lk_pred  (l_lk_pred),
    .up_pred  (l_up_pred)
  );

  tbp_chooser #(.SW(SEL_W)) u_sel (
    .clk      (clk),
    .init_en  (init_en),
    .init_s   (init_idx[SEL_W-1:0]),
    .lk_idx   (s_lk_idx),
    .up_idx   (s_up_idx),
    .upd_en   (upd_fire),
    .g_ok     (g_pred == upd_taken),
    .l_ok     (l_up_pred == upd_taken),
    .lk_global(lk_global)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid  <= 1'b0;
      pred_taken  <= 1'b0;
      pred_global <= 1'b0;
    end else begin
      pred_valid  <= fetch_valid && ready;
      pred_taken  <= lk_global ? g_pred : l_lk_pred;
      pred_global <= lk_global;
    end
  end
endmodule

// File: rtl/tbp_checker.sv
module tbp_checker #(
  parameter int GW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          ready,
  input logic          fetch_valid,
  input logic          upd_valid,
  input logic          upd_taken,
  input logic          pred_valid,
  input logic [GW-1:0] ghist
);
  AST_READY_STICKS: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready); // R1

  AST_PRED_NEEDS_FETCH: assert property (@(posedge clk) disable iff (rst)
    pred_valid |-> $past(fetch_valid)); // R2

  AST_HIST_NEWEST: assert property (@(posedge clk) disable iff (rst)
    (ready && upd_valid) |=> ghist[0] == $past(upd_taken)); // R3

  AST_HIST_SHIFTS: assert property (@(posedge clk) disable iff (rst)
    (ready && upd_valid) |=> ghist[GW-1:1] == $past(ghist[GW-2:0])); // R3

  AST_HIST_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!upd_valid || !ready) |=> $stable(ghist)); // R8

  AST_NO_PRED_IN_INIT: assert property (@(posedge clk) disable iff (rst)
    !ready |=> !pred_valid); // R10
endmodule

bind tourney_bp tbp_checker #(.GW(GHIST_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ready      (ready),
  .fetch_valid(fetch_valid),
  .upd_valid  (upd_valid),
  .upd_taken  (upd_taken),
  .pred_valid (pred_valid),
  .ghist      (ghist)
);

// File: tb/sim_tourney_bp.sv
`timescale 1ns/1ps
module sim_tourney_bp;
  localparam int PC_W = 8, AL = 2, GW = 3, LAW = 2, LHW = 3, LCW = 3, SW = 3;
  localparam int NINIT = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fetch_valid = 1'b0, upd_valid = 1'b0, upd_taken = 1'b0;
  logic [PC_W-1:0] fetch_pc = '0, upd_pc = '0;
  logic ready, pred_valid, pred_taken, pred_global;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tourney_bp #(.PC_W(PC_W), .ALIGN(AL), .GHIST_W(GW), .LADDR_W(LAW),
               .LHIST_W(LHW), .LCTR_W(LCW), .SEL_W(SW)) u0 (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .ready(ready), .pred_valid(pred_valid), .pred_taken(pred_taken),
    .pred_global(pred_global));

  // Reference model state
  logic [1:0]     mg  [2**GW];
  logic [LHW-1:0] mlh [2**LAW];
  logic [LCW-1:0] mlc [2**LHW];
  logic [1:0]     ms  [2**SW];
  logic [GW-1:0]  mgh;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 2**GW; i++) mg[i] = 2'd1;
    for (int i = 0; i < 2**LAW; i++) mlh[i] = '0;
    for (int i = 0; i < 2**LHW; i++) mlc[i] = 3'd3;
    for (int i = 0; i < 2**SW; i++) ms[i] = 2'd1;
    mgh = '0;
  endtask

  task automatic model_train(input logic [PC_W-1:0] pc, input logic t);
    logic gp, lp;
    logic [LHW-1:0] pat;
    int a, s;
    a   = pc[AL +: LAW];
    s   = pc[AL +: SW];
    pat = mlh[a];
    gp  = mg[mgh][1];
    lp  = mlc[pat][LCW-1];
    if (t && mg[mgh] != 3) mg[mgh] = mg[mgh] + 1;
    else if (!t && mg[mgh] != 0) mg[mgh] = mg[mgh] - 1;
    if (t && mlc[pat] != 7) mlc[pat] = mlc[pat] + 1;
    else if (!t && mlc[pat] != 0) mlc[pat] = mlc[pat] - 1;
    mlh[a] = {pat[LHW-2:0], t};
    if (gp == t && lp != t && ms[s] != 3) ms[s] = ms[s] + 1;
    else if (lp == t && gp != t && ms[s] != 0) ms[s] = ms[s] - 1;
    mgh = {mgh[GW-2:0], t};
  endtask

  // Called at a falling edge; leaves the bench at the next falling edge
  task automatic step(input logic fv, input logic [PC_W-1:0] fpc,
                      input logic uv, input logic [PC_W-1:0] upc,
                      input logic ut, input string tag);
    logic eg, et;
    fetch_valid = fv; fetch_pc = fpc;
    upd_valid = uv; upd_pc = upc; upd_taken = ut;
    eg = ms[fpc[AL +: SW]] >= 2;
    et = eg ? mg[mgh][1] : mlc[mlh[fpc[AL +: LAW]]][LCW-1];
    @(posedge clk);
    if (uv) model_train(upc, ut);
    @(negedge clk);
    chk(tag, "pred_valid", pred_valid, fv);
    if (fv) begin
      chk(tag, "pred_taken", pred_taken, et);
      chk(tag, "pred_global", pred_global, eg);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10: traffic during the sweep must be ignored
    fetch_valid = 1'b1; fetch_pc = 8'h04;
    upd_valid = 1'b1; upd_pc = 8'h04; upd_taken = 1'b1;
    chk("R1", "ready", ready, 0);
    for (int i = 0; i < NINIT; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R1", "ready", ready, (i == NINIT - 1) ? 1 : 0);
      chk("R10", "pred_valid", pred_valid, 0);
    end
    // R1: first lookups see reset state (local, not taken)
    step(1, 8'h00, 0, 8'h00, 0, "R1");
    step(1, 8'h04, 0, 8'h00, 0, "R10");
    step(0, 8'h00, 0, 8'h00, 0, "R2");
    // R5: always-taken branch drives local counters up
    for (int i = 0; i < 10; i++) step(1, 8'h10, 1, 8'h10, 1, "R5");
    // R4: alternating branch learned through its own history
    for (int i = 0; i < 24; i++) step(1, 8'h20, 1, 8'h20, logic'(i % 2), "R4");
    // R3: outcome fixed by the global history across several PCs
    for (int i = 0; i < 60; i++) begin
      logic [PC_W-1:0] pc;
      pc = 8'(4 * (i % 4));
      step(1, pc, 1, pc, logic'(mgh[0] ^ mgh[2] ^ 1'b1), "R3");
    end
    // R7: mixed random outcomes move the selector both ways
    for (int i = 0; i < 300; i++)
      step(1, 8'($urandom_range(0, 255)), 1, 8'($urandom_range(0, 255)),
           logic'($urandom_range(0, 1)), "R7");
    // R2: sparse fetch and sparse resolution
    for (int i = 0; i < 200; i++)
      step(logic'($urandom_range(0, 1)), 8'($urandom_range(0, 255)),
           logic'($urandom_range(0, 1)), 8'($urandom_range(0, 255)),
           logic'($urandom_range(0, 1)), "R2");
    // R9: lookup and training of the same PC in one cycle
    for (int i = 0; i < 300; i++) begin
      logic [PC_W-1:0] pc;
      pc = 8'($urandom_range(0, 255));
      step(1, pc, 1, pc, logic'($urandom_range(0, 3) != 0), "R9");
    end
    // R8: history-driven outcomes while selectors may still favour local
    for (int i = 0; i < 400; i++)
      step(1, 8'($urandom_range(0, 255)), 1, 8'($urandom_range(0, 255)),
           logic'(mgh[1] ^ mgh[0]), "R8");
    // R6: exhaustive lookup sweep over all word addresses, no training
    for (int a = 0; a < 64; a++) step(1, 8'(4 * a), 0, 8'h00, 0, "R6");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule